// File: doc/BRIEF.md
# Four-Queue Circular Pointer Manager

This block keeps the pointers for four word-sized circular queues that live in shared memory. All four are carved out of one 1 MiB-aligned base address. Each region is as long as a programmable size, and the regions sit back to back in a fixed order. Every pointer is kept as a byte offset inside its own region and is shown as a full address. Each step moves a pointer by 4 bytes, and a pointer wraps to the start of its region when it reaches the end.

A host agent reaches the queues through two port addresses, an inbound one and an outbound one. Each access is turned into a single memory access at the address given by a hardware-owned pointer, and that pointer then advances. An access that would overrun or underrun its queue is refused without any memory access. The CPU side programs a control word and the base, and it moves the software-owned pointers by writing new addresses. A read-back port returns every register as a full address.

One host access at a time is handled by a three-state machine. In `ST_IDLE` the block is ready. An accepted request moves to `ST_XFER` when the target queue can take it, or to `ST_REFUSE` when it is full or empty. Both of those states last one cycle and return to `ST_IDLE`.

Top module: `qmq_top`

## Requirements
- R1: After reset, the control word, the base and all eight pointer read-backs are zero, `host_ready` is high, `post_irq` is low and `q_empty` is all ones.
- R2: Control word (select 0) bit 0 is the enable and bits 5:1 are the size code. The queue size is the code times 16384 bytes. The base (select 1) keeps only bits 31:20 and reads back with bits 19:0 zero.
- R3: Queue q begins at base + q·size. The queue order is 0 inbound free, 1 inbound post, 2 outbound post, 3 outbound free. Select 2+2q reads queue q's head address and select 3+2q reads its tail address. Any write to the control word returns all pointers to their region starts.
- R4: Each pointer step adds 4 bytes. A step that reaches the region size wraps the pointer to the region start.
- R5: `q_empty[q]` is high when head equals tail. `q_full[q]` is high when the head, stepped once, would equal the tail.
- R6: A host write on the inbound port (`host_port`=0, `host_we`=1) writes memory at the inbound post head and advances that head. A host read on the outbound port reads at the outbound post tail and advances that tail.
- R7: A host read on the inbound port reads at the inbound free tail and advances it. A host write on the outbound port writes at the outbound free head and advances it.
- R8: A host read of an empty queue makes no memory access, moves no pointer, raises `host_miss` and returns 0xFFFFFFFF on `host_rdata`.
- R9: A host write to a full queue is dropped with `host_miss` raised, no memory access and no pointer change.
- R10: CPU writes load only the software-owned pointers: inbound free head (select 2), inbound post tail (5), outbound post head (6) and outbound free tail (9). The value must be word aligned and inside that queue's region, or the write is ignored. Writes to hardware-owned pointer selects are ignored.
- R11: `post_irq` is high exactly when queues are enabled and the inbound post queue is not empty.
- R12: While the enable bit is clear or the size code is zero, host requests give no `host_done`, no memory access and no pointer movement.
- R13: A request is accepted when `host_ready` is high. `host_done` comes one cycle later for exactly one cycle, with `host_ready` low in that cycle. Memory outputs are valid in that same cycle, and `host_rdata` returns `mem_rdata` on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | CPU register write strobe |
| cfg_sel | input | 4 | CPU write register select |
| cfg_wdata | input | 32 | CPU write data |
| cfg_rsel | input | 4 | Read-back register select |
| cfg_rdata | output | 32 | Read-back data (combinational) |
| host_req | input | 1 | Host port access request |
| host_port | input | 1 | 0 inbound port, 1 outbound port |
| host_we | input | 1 | 1 write, 0 read |
| host_ready | output | 1 | Block idle, request can be taken |
| host_done | output | 1 | Access finished this cycle |
| host_miss | output | 1 | Access refused (full or empty queue) |
| host_rdata | output | 32 | Read data returned to the host |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_rdata | input | 32 | Memory read data (same cycle) |
| q_empty | output | 4 | Per-queue empty flags |
| q_full | output | 4 | Per-queue full flags |
| post_irq | output | 1 | Inbound post queue interrupt request |

## Verification
Every cycle, the bound checker confirms four things: memory addresses are word aligned and fall inside the accessed queue's region, no memory write or read goes to a queue that was full or empty when the request was decided, refused reads return all ones, and `host_done` is a one-cycle pulse that never follows a request made while disabled. Exact pointer values need the bench's reference model and its end-to-end scenarios to show. These cover wrap-around at the region end, the fill up to the full condition, rejection of misaligned, out-of-region and hardware-owned pointer writes, the region placement for different size codes, and the interrupt level.

// File: rtl/qmq_pkg.sv
package qmq_pkg;
    localparam int NQ    = 4;
    localparam int QW    = $clog2(NQ);
    localparam int SEL_W = $clog2(2 + 2 * NQ);

    localparam int Q_IN_FREE  = 0;
    localparam int Q_IN_POST  = 1;
    localparam int Q_OUT_POST = 2;
    localparam int Q_OUT_FREE = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_REFUSE
    } port_state_e;

    // select of the pointer that software owns for queue q
    function automatic int sw_sel(input int q);
        return 2 + 2 * q + (q % 2);
    endfunction
endpackage

// File: rtl/qmq_ring.sv
module qmq_ring #(
    parameter int OFF_W        = 19,
    parameter bit SW_OWNS_HEAD = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             hw_step,
    input  logic             sw_load,
    input  logic [OFF_W-1:0] span,
    input  logic [OFF_W-1:0] sw_off,
    output logic [OFF_W-1:0] head_off,
    output logic [OFF_W-1:0] tail_off,
    output logic             empty,
    output logic             full
);
    function automatic logic [OFF_W-1:0] bump(input logic [OFF_W-1:0] x,
                                              input logic [OFF_W-1:0] lim);
        logic [OFF_W:0] s;
        s = {1'b0, x} + (OFF_W+1)'(4);
        return (s >= {1'b0, lim}) ? '0 : s[OFF_W-1:0];
    endfunction

    logic [OFF_W-1:0] head_q, tail_q, head_n, tail_n;

    generate
        if (SW_OWNS_HEAD) begin : g_sw_head
            always_comb begin
                head_n = head_q;
                tail_n = tail_q;
                if (sw_load) head_n = sw_off;
                if (hw_step) tail_n = bump(tail_q, span);
            end
        end else begin : g_sw_tail
            always_comb begin
                head_n = head_q;
                tail_n = tail_q;
                if (sw_load) tail_n = sw_off;
                if (hw_step) head_n = bump(head_q, span);
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else if (clear) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_n;
            tail_q <= tail_n;
        end
    end

    assign head_off = head_q;
    assign tail_off = tail_q;
    assign empty    = (head_q == tail_q);
    assign full     = (bump(head_q, span) == tail_q);
endmodule

// File: rtl/qmq_regs.sv
module qmq_regs
    import qmq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 5,
    parameter int UNIT_LOG2 = 14,
    parameter int BASE_BITS = 12,
    parameter int OFF_W     = 19
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [SEL_W-1:0]            cfg_sel,
    input  logic [ADDR_W-1:0]           cfg_wdata,
    input  logic [SEL_W-1:0]            cfg_rsel,
    output logic [ADDR_W-1:0]           cfg_rdata,
    input  logic [NQ-1:0][OFF_W-1:0]    head_off,
    input  logic [NQ-1:0][OFF_W-1:0]    tail_off,
    output logic                        q_on,
    output logic                        clear,
    output logic [OFF_W-1:0]            span,
    output logic [NQ-1:0][ADDR_W-1:0]   region_start,
    output logic [NQ-1:0]               sw_load,
    output logic [NQ-1:0][OFF_W-1:0]    sw_off
);
    localparam int LOW_W = ADDR_W - BASE_BITS;

    logic                 en_q;
    logic [SIZE_W-1:0]    code_q;
    logic [BASE_BITS-1:0] base_q;
    logic [ADDR_W-1:0]    base_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            code_q <= '0;
            base_q <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_W'(0)) begin
                en_q   <= cfg_wdata[0];
                code_q <= cfg_wdata[SIZE_W:1];
            end
            if (cfg_sel == SEL_W'(1)) begin
                base_q <= cfg_wdata[ADDR_W-1 -: BASE_BITS];
            end
        end
    end

    assign base_addr = {base_q, {LOW_W{1'b0}}};
    assign span      = {code_q, {UNIT_LOG2{1'b0}}};
    assign q_on      = en_q && (code_q != '0);
    assign clear     = cfg_we && (cfg_sel == SEL_W'(0));

    generate
        for (genvar q = 0; q < NQ; q++) begin : g_q
            logic [ADDR_W-1:0] diff;
            logic              fits;
            assign region_start[q] = base_addr + ADDR_W'(q) * ADDR_W'(span);
            assign diff            = cfg_wdata - region_start[q];
            assign fits            = (diff < ADDR_W'(span)) && (diff[1:0] == 2'b00);
            assign sw_load[q]      = cfg_we && (cfg_sel == SEL_W'(sw_sel(q))) && fits;
            assign sw_off[q]       = diff[OFF_W-1:0];
        end
    endgenerate

    always_comb begin
        cfg_rdata = '0;
        if (cfg_rsel == SEL_W'(0)) begin
            cfg_rdata = ADDR_W'({code_q, en_q});
        end else if (cfg_rsel == SEL_W'(1)) begin
            cfg_rdata = base_addr;
        end else begin
            for (int q = 0; q < NQ; q++) begin
                if (cfg_rsel == SEL_W'(2 + 2 * q))
                    cfg_rdata = region_start[q] + ADDR_W'(head_off[q]);
                if (cfg_rsel == SEL_W'(3 + 2 * q))
                    cfg_rdata = region_start[q] + ADDR_W'(tail_off[q]);
            end
        end
    end
endmodule

// File: rtl/qmq_port_fsm.sv
module qmq_port_fsm
    import qmq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_on,
    input  logic              host_req,
    input  logic              host_port,
    input  logic              host_we,
    input  logic [NQ-1:0]     q_empty,
    input  logic [NQ-1:0]     q_full,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              host_ready,
    output logic              host_done,
    output logic              host_miss,
    output logic [DATA_W-1:0] host_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [QW-1:0]     cur_q,
    output logic [NQ-1:0]     hw_step
);
    port_state_e st_q, st_n;
    logic [QW-1:0] q_q, pick;
    logic          blocked;

    // queue index: {port, we} -> 0 in-free, 1 in-post, 2 out-post, 3 out-free
    assign pick    = {host_port, host_we};
    assign blocked = host_we ? q_full[pick] : q_empty[pick];

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE:   if (host_req && q_on) st_n = blocked ? ST_REFUSE : ST_XFER;
            ST_XFER:   st_n = ST_IDLE;
            ST_REFUSE: st_n = ST_IDLE;
            default:   st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            q_q  <= '0;
        end else begin
            st_q <= st_n;
            if (st_q == ST_IDLE && host_req && q_on) q_q <= pick;
        end
    end

    always_comb begin
        host_ready = 1'b0;
        host_done  = 1'b0;
        host_miss  = 1'b0;
        host_rdata = '0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        hw_step    = '0;
        unique case (st_q)
            ST_IDLE: host_ready = 1'b1;
            ST_XFER: begin
                host_done   = 1'b1;
                mem_req     = 1'b1;
                mem_we      = q_q[0];
                host_rdata  = q_q[0] ? '0 : mem_rdata;
                hw_step[q_q] = 1'b1;
            end
            ST_REFUSE: begin
                host_done  = 1'b1;
                host_miss  = 1'b1;
                host_rdata = q_q[0] ? '0 : '1;
            end
            default: host_ready = 1'b0;
        endcase
    end

    assign cur_q = q_q;
endmodule

// File: rtl/qmq_top.sv
module qmq_top
    import qmq_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 5,
    parameter int UNIT_LOG2 = 14,
    parameter int BASE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [SEL_W-1:0]  cfg_rsel,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              host_req,
    input  logic              host_port,
    input  logic              host_we,
    output logic              host_ready,
    output logic              host_done,
    output logic              host_miss,
    output logic [ADDR_W-1:0] host_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic [NQ-1:0]     q_empty,
    output logic [NQ-1:0]     q_full,
    output logic              post_irq
);
    localparam int OFF_W = SIZE_W + UNIT_LOG2;

    logic                      q_on, clear;
    logic [OFF_W-1:0]          span;
    logic [NQ-1:0][ADDR_W-1:0] region_start;
    logic [NQ-1:0]             sw_load, hw_step;
    logic [NQ-1:0][OFF_W-1:0]  sw_off, head_off, tail_off, hw_ptr;
    logic [QW-1:0]             cur_q;

    qmq_regs #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .UNIT_LOG2(UNIT_LOG2),
        .BASE_BITS(BASE_BITS), .OFF_W(OFF_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
        .head_off(head_off), .tail_off(tail_off), .q_on(q_on), .clear(clear),
        .span(span), .region_start(region_start), .sw_load(sw_load), .sw_off(sw_off)
    );

    generate
        for (genvar q = 0; q < NQ; q++) begin : g_ring
            qmq_ring #(.OFF_W(OFF_W), .SW_OWNS_HEAD((q % 2) == 0)) u_ring (
                .clk(clk), .rst_n(rst_n), .clear(clear), .hw_step(hw_step[q]),
                .sw_load(sw_load[q]), .span(span), .sw_off(sw_off[q]),
                .head_off(head_off[q]), .tail_off(tail_off[q]),
                .empty(q_empty[q]), .full(q_full[q])
            );
            // even queues are drained by the host, odd queues are filled by it
            assign hw_ptr[q] = (q % 2 == 1) ? head_off[q] : tail_off[q];
        end
    endgenerate

    qmq_port_fsm #(.DATA_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .q_on(q_on), .host_req(host_req),
        .host_port(host_port), .host_we(host_we), .q_empty(q_empty), .q_full(q_full),
        .mem_rdata(mem_rdata), .host_ready(host_ready), .host_done(host_done),
        .host_miss(host_miss), .host_rdata(host_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .cur_q(cur_q), .hw_step(hw_step)
    );

    assign mem_addr = region_start[cur_q] + ADDR_W'(hw_ptr[cur_q]);
    assign post_irq = q_on && !q_empty[Q_IN_POST];
endmodule

// File: rtl/qmq_chk.sv
module qmq_chk
    import qmq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 19
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      q_on,
    input logic                      host_ready,
    input logic                      host_done,
    input logic                      host_miss,
    input logic [ADDR_W-1:0]         host_rdata,
    input logic                      mem_req,
    input logic                      mem_we,
    input logic [ADDR_W-1:0]         mem_addr,
    input logic [QW-1:0]             cur_q,
    input logic [NQ-1:0]             q_empty,
    input logic [NQ-1:0]             q_full,
    input logic [OFF_W-1:0]          span,
    input logic [NQ-1:0][ADDR_W-1:0] region_start
);
    logic [NQ-1:0] full_d, empty_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_d  <= '0;
            empty_d <= '1;
        end else begin
            full_d  <= q_full;
            empty_d <= q_empty;
        end
    end

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00); // R4
    AST_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && q_on) |-> (mem_addr - region_start[cur_q]) < ADDR_W'(span)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !full_d[cur_q]); // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !empty_d[cur_q]); // R8
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        host_miss |-> !mem_req); // R8
    AST_MISS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (host_miss && !cur_q[0]) |-> host_rdata == '1); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> (host_ready && !host_done)); // R13
    AST_OFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ready && !q_on) |=> !host_done); // R12
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        q_on |-> (q_full & q_empty) == '0); // R5
endmodule

bind qmq_top qmq_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .q_on(q_on), .host_ready(host_ready),
    .host_done(host_done), .host_miss(host_miss), .host_rdata(host_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .cur_q(cur_q),
    .q_empty(q_empty), .q_full(q_full), .span(span), .region_start(region_start)
);

// File: tb/test_qmq_top.sv
module test_qmq_top;
    import qmq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 32;
    localparam int UNIT       = 16384;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [SEL_W-1:0] cfg_sel = '0, cfg_rsel = '0;
    logic [AW-1:0] cfg_wdata = '0, cfg_rdata;
    logic host_req = 1'b0, host_port = 1'b0, host_we = 1'b0;
    logic host_ready, host_done, host_miss;
    logic [AW-1:0] host_rdata;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr, mem_rdata;
    logic [NQ-1:0] q_empty, q_full;
    logic post_irq;

    int nchk = 0, nfail = 0, cycles = 0;
    bit finished = 0;

    bit          m_en;
    int unsigned m_code, m_base;
    int unsigned m_hd[NQ], m_tl[NQ];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign mem_rdata = ~mem_addr;

    qmq_top i_qmq_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
        .host_req(host_req), .host_port(host_port), .host_we(host_we),
        .host_ready(host_ready), .host_done(host_done), .host_miss(host_miss),
        .host_rdata(host_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .q_empty(q_empty),
        .q_full(q_full), .post_irq(post_irq)
    );

    function automatic int unsigned f_span();
        return m_code * UNIT;
    endfunction
    function automatic bit f_on();
        return m_en && (m_code != 0);
    endfunction
    function automatic logic [AW-1:0] f_start(input int q);
        return m_base + q * f_span();
    endfunction
    function automatic int unsigned f_bump(input int unsigned x);
        return (x + 4 >= f_span()) ? 0 : x + 4;
    endfunction
    function automatic bit f_empty(input int q);
        return m_hd[q] == m_tl[q];
    endfunction
    function automatic bit f_full(input int q);
        return f_bump(m_hd[q]) == m_tl[q];
    endfunction

    task automatic finish_up();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            nfail++;
            $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WATCHDOG);
            finish_up();
        end
    end

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_read(input int sel, output logic [AW-1:0] val);
        @(negedge clk);
        cfg_rsel = SEL_W'(sel);
        #1;
        val = cfg_rdata;
    endtask

    task automatic cfg_write(input int sel, input logic [AW-1:0] data);
        logic [AW-1:0] diff;
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = SEL_W'(sel); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 0) begin
            m_en = data[0]; m_code = data[5:1];
            for (int q = 0; q < NQ; q++) begin m_hd[q] = 0; m_tl[q] = 0; end
        end else if (sel == 1) begin
            m_base = data & 32'hFFF0_0000;
        end else begin
            for (int q = 0; q < NQ; q++) begin
                if (sel == 2 + 2 * q + (q % 2)) begin
                    diff = data - f_start(q);
                    if (diff < f_span() && diff[1:0] == 2'b00) begin
                        if (q % 2 == 0) m_hd[q] = diff; else m_tl[q] = diff;
                    end
                end
            end
        end
    endtask

    task automatic check_ptrs(input string tag);
        logic [AW-1:0] v;
        for (int q = 0; q < NQ; q++) begin
            cfg_read(2 + 2 * q, v); chk({tag, " head"}, v, f_start(q) + m_hd[q]);
            cfg_read(3 + 2 * q, v); chk({tag, " tail"}, v, f_start(q) + m_tl[q]);
        end
    endtask

    task automatic host_op(input bit port, input bit we, input string tag);
        int q;
        bit on, blk;
        logic [AW-1:0] ea;
        q = port * 2 + we;
        on = f_on();
        blk = we ? f_full(q) : f_empty(q);
        @(negedge clk);
        chk("R13 ready before request", host_ready, 1);
        host_req = 1'b1; host_port = port; host_we = we;
        @(negedge clk);
        host_req = 1'b0;
        if (!on) begin
            chk({tag, " no done while off"}, host_done, 0);
            chk({tag, " no mem while off"}, mem_req, 0);
        end else begin
            chk("R13 done", host_done, 1);
            chk("R13 busy", host_ready, 0);
            if (blk) begin
                chk({tag, " miss"}, host_miss, 1);
                chk({tag, " no mem"}, mem_req, 0);
                if (!we) chk("R8 ones", host_rdata, '1);
            end else begin
                ea = f_start(q) + (we ? m_hd[q] : m_tl[q]);
                chk({tag, " hit"}, host_miss, 0);
                chk({tag, " mem_req"}, mem_req, 1);
                chk({tag, " mem_we"}, mem_we, we);
                chk({tag, " addr"}, mem_addr, ea);
                if (!we) chk("R13 rdata", host_rdata, ~ea);
                if (we) m_hd[q] = f_bump(m_hd[q]); else m_tl[q] = f_bump(m_tl[q]);
            end
        end
    endtask

    task automatic check_flags(input string tag);
        @(negedge clk);
        for (int q = 0; q < NQ; q++) begin
            chk({tag, " R5 empty"}, q_empty[q], f_empty(q));
            chk({tag, " R5 full"}, q_full[q], f_on() && f_full(q));
        end
        chk({tag, " R11 irq"}, post_irq, f_on() && !f_empty(1));
    endtask

    initial begin
        logic [AW-1:0] v;
        int unsigned seed;
        seed = $urandom(32'd4711);
        m_en = 0; m_code = 0; m_base = 0;
        for (int q = 0; q < NQ; q++) begin m_hd[q] = 0; m_tl[q] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cfg_read(0, v); chk("R1 ctrl", v, 0);
        cfg_read(1, v); chk("R1 base", v, 0);
        check_ptrs("R1");
        chk("R1 ready", host_ready, 1);
        chk("R1 irq", post_irq, 0);
        chk("R1 empty", q_empty, 4'hF);

        // R12 disabled
        host_op(0, 1, "R12");
        cfg_write(0, 32'h2);
        host_op(1, 0, "R12");
        host_op(0, 1, "R12");
        check_ptrs("R12");

        // R2 / R3 configuration
        cfg_write(1, 32'h1234_5678);
        cfg_read(1, v); chk("R2 base mask", v, 32'h1230_0000);
        cfg_write(0, 32'h5);
        cfg_read(0, v); chk("R2 ctrl", v, 32'h5);
        cfg_read(6, v); chk("R2 size code 2", v, 32'h1231_0000);
        cfg_write(0, 32'h3);
        cfg_read(4, v); chk("R3 inbound post start", v, 32'h1230_4000);
        cfg_read(9, v); chk("R3 outbound free start", v, 32'h1230_C000);
        check_ptrs("R3");

        // R8 empty reads
        host_op(0, 0, "R8");
        host_op(1, 0, "R8");

        // R6 inbound posts, R11 irq
        for (int i = 0; i < 3; i++) host_op(0, 1, "R6");
        check_flags("R11 posted");

        // R10 ignored and accepted software writes
        cfg_write(4, f_start(1) + 8);
        cfg_write(5, f_start(1) + 2);
        cfg_write(5, f_start(1) + f_span());
        check_ptrs("R10 ignored");
        cfg_write(5, f_start(1) + 12);
        check_ptrs("R10 loaded");
        check_flags("R11 drained");

        // R7 inbound free reads
        cfg_write(2, f_start(0) + 8);
        host_op(0, 0, "R7");
        host_op(0, 0, "R7");
        host_op(0, 0, "R8");

        // R9 fill outbound free, R4 wrap of head
        for (int i = 0; i < 4095; i++) host_op(1, 1, "R7");
        check_flags("R9 full");
        host_op(1, 1, "R9");
        check_ptrs("R9");
        cfg_write(9, f_start(3) + 8);
        host_op(1, 1, "R4");
        host_op(1, 1, "R4");
        cfg_read(8, v); chk("R4 head wrapped", v, f_start(3) + 4);
        host_op(1, 1, "R9");

        // R4 wrap of outbound post tail
        cfg_write(6, f_start(2) + f_span() - 4);
        for (int i = 0; i < 4095; i++) host_op(1, 0, "R6");
        cfg_write(6, f_start(2) + 8);
        for (int i = 0; i < 3; i++) host_op(1, 0, "R4");
        cfg_read(7, v); chk("R4 tail wrapped", v, f_start(2) + 8);
        host_op(1, 0, "R8");

        // R12 disable after use
        cfg_write(0, 32'h2);
        host_op(0, 1, "R12");
        check_flags("R12 off");
        check_ptrs("R12 off");

        // constrained random mix
        cfg_write(0, 32'h3);
        for (int it = 0; it < 400; it++) begin
            int k, q, n;
            k = $urandom % 10;
            q = $urandom % NQ;
            if (k < 6) begin
                host_op($urandom % 2, $urandom % 2, "R6 random");
            end else if (k < 8) begin
                n = 4 * ($urandom % 4);
                if (q % 2 == 0) cfg_write(2 + 2 * q, f_start(q) + ((m_hd[q] + n) % f_span()));
                else            cfg_write(3 + 2 * q, f_start(q) + ((m_tl[q] + n) % f_span()));
            end else if (k == 8) begin
                if (q % 2 == 0) cfg_write(3 + 2 * q, f_start(q) + 4);
                else            cfg_write(2 + 2 * q, f_start(q) + 4);
                cfg_write(2 + 2 * q + (q % 2), f_start(q) + 1 + 4 * ($urandom % 8));
                cfg_write(2 + 2 * q + (q % 2), f_start(q) + f_span() + 4 * ($urandom % 8));
            end else begin
                cfg_write(0, {26'b0, 5'(1 + $urandom % 3), 1'b1});
            end
            if (it % 25 == 24) begin
                check_ptrs("R10 random");
                check_flags("R5 random");
            end
        end
        check_ptrs("R4 final");
        finish_up();
    end
endmodule